// File: doc/BRIEF.md
# Host Port Slave Interface

This block lets an external host read and write a 32-bit internal memory space through a 16-bit port that carries each word as two half-words. The host opens an access by pulling chip select low and then dropping one of its two data strobes. The block derives its internal strobe from those three pins. When that strobe falls it captures the select inputs: register select, read/write and half-word identifier. It holds three 32-bit registers: a control register, an address register and a data register. Accesses to the data register turn into word transfers on an internal request/acknowledge memory port, with an optional post-increment of the address.

An active-high `not_ready` output tells the host to wait. It is forced low whenever chip select is high. It rises while the first half-word of a data read fetches its word, and while a completed data write or an autoincrement read prefetch is still in flight. Control and address register accesses never touch it. The host obeys a simple protocol. It waits until `not_ready` is low before dropping a strobe, and again before raising it. It keeps the strobe low for at least two clock cycles and high for at least two cycles between accesses. All host pins are taken as synchronous to `clk`.

Top module: `host_port_slave`

## Requirements
- R1: The internal strobe is `cs_n | ~(dstb_a_n ^ dstb_b_n)` and is active low, so an access starts only while chip select is low and exactly one data strobe is low. Both strobes low, both high, or chip select high starts no access and changes no register.
- R2: `reg_sel`, `rd_wr_n` and `half_sel` are captured in the cycle the strobe falls. Changing them while the strobe stays low does not alter the access.
- R3: Register select codes are 2'b00 control, 2'b01 data with autoincrement, 2'b10 address and 2'b11 data without increment. `half_sel` 0 selects bits [15:0] and 1 selects bits [31:16]. Write data on `hd_in` is taken when the strobe rises. Read data appears on `hd_out`, and `hd_oe` is 1 only while the strobe is low on a read access (`rd_wr_n` = 1).
- R4: `not_ready` is 0 whenever `cs_n` is 1, even while a memory transfer is outstanding.
- R5: A data read with `half_sel` = 0 raises `mem_req` with `mem_we` = 0 at the address register. `not_ready` is 1 from the strobe fall until the returned word is loaded into the data register.
- R6: A data write stores the low half first and then the high half. When the high-half strobe rises, one memory write of the assembled 32-bit word goes to the address register, and `not_ready` stays 1 until it is acknowledged.
- R7: With select 2'b01, the address register grows by 4 after each completed word write. After the high half of a read, the address grows by 4 and the word at the new address is prefetched while `not_ready` is 1. The next 2'b01 low-half read uses that word with no new memory request.
- R8: Control and address register reads and writes never raise `not_ready` and never issue a memory request.
- R9: If a data write or prefetch is still outstanding when `cs_n` falls, `not_ready` is 1 as soon as `cs_n` is low.
- R10: A data read with select 2'b11 issues a fresh memory read on every low half and leaves the address register unchanged.
- R11: While `mem_req` is 1 and `mem_ack` is 0, the next cycle keeps `mem_req` at 1 with `mem_addr`, `mem_we` and `mem_wdata` unchanged.
- R12: After reset, `not_ready`, `mem_req` and `hd_oe` are 0, and the control and address registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low |
| dstb_a_n | input | 1 | Host data strobe A |
| dstb_b_n | input | 1 | Host data strobe B |
| reg_sel | input | 2 | Register select code |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| half_sel | input | 1 | Half-word identifier |
| hd_in | input | 16 | Host write data |
| hd_out | output | 16 | Host read data |
| hd_oe | output | 1 | Host data output enable |
| not_ready | output | 1 | 1 = host must wait |
| mem_req | output | 1 | Memory port request, held until acknowledge |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | 32 | Memory port byte address |
| mem_wdata | output | 32 | Memory port write data |
| mem_ack | input | 1 | Memory port acknowledge, one cycle |
| mem_rdata | input | 32 | Memory port read data |

## Verification
The hardest case to reach from the ports is chip select falling while an earlier write or prefetch is still outstanding. It only happens when the memory is slow and the host drops and reasserts chip select between accesses. The bench stretches the memory latency to eight cycles and toggles `cs_n` right after a write commit. The second hard case is the low-half autoincrement read served from a prefetched word. The bench reaches it with a high-half autoincrement read followed by a control access that must not spoil the prefetch. It then counts memory request cycles around the next low half. A seeded random mix of word writes, reads, address loads and control accesses, with random memory latency, covers the remaining interleavings.

// File: rtl/hps_pkg.sv
package hps_pkg;

    // Register select codes seen on the host port
    typedef enum logic [1:0] {
        RS_CTRL     = 2'b00,
        RS_DATA_INC = 2'b01,
        RS_ADDR     = 2'b10,
        RS_DATA     = 2'b11
    } regsel_e;

    // Captured select signals of one host access
    typedef struct packed {
        regsel_e rs;
        logic    rnw;
        logic    hw;
    } hsel_t;

    // Internal memory engine state
    typedef enum logic [1:0] {
        EN_IDLE,
        EN_FETCH,
        EN_WRITE,
        EN_PREF
    } eng_e;

    function automatic logic sel_is_data(regsel_e r);
        return r[0];
    endfunction

    function automatic logic sel_is_inc(regsel_e r);
        return r == RS_DATA_INC;
    endfunction

endpackage

// File: rtl/hps_front.sv
module hps_front
    import hps_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  ds_a_n,
    input  logic  ds_b_n,
    input  hsel_t sel_in,
    output logic  strobe_n,
    output logic  acc_fall,
    output logic  acc_rise,
    output hsel_t sel_cur
);

    logic  strobe_q;
    hsel_t sel_cap;

    // Strobe is active only with chip select low and the two data strobes differing
    assign strobe_n = cs_n | ~(ds_a_n ^ ds_b_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b1;
            sel_cap  <= '0;
        end else begin
            strobe_q <= strobe_n;
            if (acc_fall) begin
                sel_cap <= sel_in;
            end
        end
    end

    assign acc_fall = strobe_q & ~strobe_n;
    assign acc_rise = ~strobe_q & strobe_n;
    // In the fall cycle the live pins are used, afterwards the captured copy
    assign sel_cur  = acc_fall ? sel_in : sel_cap;

    // R2: the selection seen by the core does not move while the strobe stays low
    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && !acc_fall) |-> $stable(sel_cur));

endmodule

// File: rtl/hps_core.sv
module hps_core
    import hps_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int ADDR_STEP = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  strobe_n,
    input  logic                  acc_fall,
    input  logic                  acc_rise,
    input  hsel_t                 sel_cur,
    input  logic [HALF_W-1:0]     hd_in,
    output logic [HALF_W-1:0]     hd_out,
    output logic                  hd_oe,
    output logic                  not_ready,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [2*HALF_W-1:0]   mem_addr,
    output logic [2*HALF_W-1:0]   mem_wdata,
    input  logic                  mem_ack,
    input  logic [2*HALF_W-1:0]   mem_rdata
);

    localparam int WORD_W = 2 * HALF_W;
    localparam logic [WORD_W-1:0] STEP_W = WORD_W'(ADDR_STEP);

    function automatic logic [WORD_W-1:0] put_half(logic [WORD_W-1:0] w, logic hi,
                                                   logic [HALF_W-1:0] h);
        logic [WORD_W-1:0] r;
        r = w;
        if (hi) r[WORD_W-1:HALF_W] = h;
        else    r[HALF_W-1:0]      = h;
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] get_half(logic [WORD_W-1:0] w, logic hi);
        return hi ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

    logic [WORD_W-1:0] ctrl_r, addr_r, data_r, src_w;
    logic              pref_ok, inc_pend, busy;
    logic              start_fetch, wr_done, rd_tail;
    eng_e              eng;

    assign busy = (eng != EN_IDLE);

    // Low-half data read needs a fetch unless a prefetched word is waiting
    assign start_fetch = acc_fall & sel_cur.rnw & sel_is_data(sel_cur.rs) & ~sel_cur.hw
                       & ~(sel_is_inc(sel_cur.rs) & pref_ok);
    assign wr_done = acc_rise & ~sel_cur.rnw;
    assign rd_tail = acc_rise & sel_cur.rnw & sel_cur.hw & sel_is_inc(sel_cur.rs);

    always_comb begin
        case (sel_cur.rs)
            RS_CTRL: src_w = ctrl_r;
            RS_ADDR: src_w = addr_r;
            default: src_w = data_r;
        endcase
    end

    assign hd_out    = get_half(src_w, sel_cur.hw);
    assign hd_oe     = ~strobe_n & sel_cur.rnw;
    assign not_ready = ~cs_n & (busy | start_fetch);
    assign mem_req   = busy;
    assign mem_we    = (eng == EN_WRITE);
    assign mem_addr  = addr_r;
    assign mem_wdata = data_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r   <= '0;
            addr_r   <= '0;
            data_r   <= '0;
            pref_ok  <= 1'b0;
            inc_pend <= 1'b0;
            eng      <= EN_IDLE;
        end else begin
            case (eng)
                EN_IDLE: begin
                    if (start_fetch) begin
                        eng <= EN_FETCH;
                    end
                    if (wr_done) begin
                        case (sel_cur.rs)
                            RS_CTRL: ctrl_r <= put_half(ctrl_r, sel_cur.hw, hd_in);
                            RS_ADDR: begin
                                addr_r  <= put_half(addr_r, sel_cur.hw, hd_in);
                                pref_ok <= 1'b0;
                            end
                            default: begin
                                data_r <= put_half(data_r, sel_cur.hw, hd_in);
                                if (sel_cur.hw) begin
                                    eng      <= EN_WRITE;
                                    inc_pend <= sel_is_inc(sel_cur.rs);
                                    pref_ok  <= 1'b0;
                                end
                            end
                        endcase
                    end
                    if (rd_tail) begin
                        addr_r <= addr_r + STEP_W;
                        eng    <= EN_PREF;
                    end
                end
                EN_FETCH, EN_PREF: begin
                    if (mem_ack) begin
                        data_r  <= mem_rdata;
                        pref_ok <= (eng == EN_PREF);
                        eng     <= EN_IDLE;
                    end
                end
                EN_WRITE: begin
                    if (mem_ack) begin
                        eng <= EN_IDLE;
                        if (inc_pend) begin
                            addr_r <= addr_r + STEP_W;
                        end
                    end
                end
                default: eng <= EN_IDLE;
            endcase
        end
    end

    // R5: a low-half data read fetch becomes a memory read request next cycle
    assert_fetch_issue_R5: assert property (@(posedge clk) disable iff (rst)
        (start_fetch && !busy) |=> (mem_req && !mem_we));

    // R6: the high-half data write becomes a memory write request next cycle
    assert_write_issue_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_done && sel_is_data(sel_cur.rs) && sel_cur.hw) |=> (mem_req && mem_we));

    // R7: an acknowledged autoincrement write moves the address by one step
    assert_wr_inc_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && inc_pend) |=> (mem_addr == $past(mem_addr) + STEP_W));

    // R8: control and address accesses never start a memory transfer
    assert_regacc_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && (acc_fall || acc_rise) && !sel_is_data(sel_cur.rs)) |=> !mem_req);

    // R9: an outstanding transfer shows as not ready at the chip select fall
    assert_busy_cs_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && mem_req) |-> not_ready);

    // R11: a pending memory request keeps its address, direction and data
    assert_port_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

endmodule

// File: rtl/host_port_slave.sv
module host_port_slave
    import hps_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int ADDR_STEP = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                dstb_a_n,
    input  logic                dstb_b_n,
    input  logic [1:0]          reg_sel,
    input  logic                rd_wr_n,
    input  logic                half_sel,
    input  logic [HALF_W-1:0]   hd_in,
    output logic [HALF_W-1:0]   hd_out,
    output logic                hd_oe,
    output logic                not_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic [2*HALF_W-1:0] mem_addr,
    output logic [2*HALF_W-1:0] mem_wdata,
    input  logic                mem_ack,
    input  logic [2*HALF_W-1:0] mem_rdata
);

    hsel_t sel_in, sel_cur;
    logic  strobe_n, acc_fall, acc_rise;

    assign sel_in = '{rs: regsel_e'(reg_sel), rnw: rd_wr_n, hw: half_sel};

    hps_front u_front (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .ds_a_n   (dstb_a_n),
        .ds_b_n   (dstb_b_n),
        .sel_in   (sel_in),
        .strobe_n (strobe_n),
        .acc_fall (acc_fall),
        .acc_rise (acc_rise),
        .sel_cur  (sel_cur)
    );

    hps_core #(
        .HALF_W    (HALF_W),
        .ADDR_STEP (ADDR_STEP)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .strobe_n  (strobe_n),
        .acc_fall  (acc_fall),
        .acc_rise  (acc_rise),
        .sel_cur   (sel_cur),
        .hd_in     (hd_in),
        .hd_out    (hd_out),
        .hd_oe     (hd_oe),
        .not_ready (not_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: tb/host_port_slave_test.sv
`timescale 1ns/1ps
module host_port_slave_test;

    localparam logic [1:0] S_CTRL = 2'b00;
    localparam logic [1:0] S_INC  = 2'b01;
    localparam logic [1:0] S_ADDR = 2'b10;
    localparam logic [1:0] S_DATA = 2'b11;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, dstb_a_n, dstb_b_n;
    logic [1:0]  reg_sel;
    logic        rd_wr_n, half_sel;
    logic [15:0] hd_in, hd_out;
    logic        hd_oe, not_ready, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack;

    always #2 clk = ~clk;

    host_port_slave uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .dstb_a_n(dstb_a_n), .dstb_b_n(dstb_b_n),
        .reg_sel(reg_sel), .rd_wr_n(rd_wr_n), .half_sel(half_sel), .hd_in(hd_in),
        .hd_out(hd_out), .hd_oe(hd_oe), .not_ready(not_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] mem     [64];
    logic [31:0] exp_mem [64];
    logic [31:0] exp_ctrl, exp_addr;
    int  mem_lat = 2;
    int  lat_cnt = 0;
    int  req_cycles = 0, busy_cycles = 0, hold_viol = 0;
    bit  hold_open = 0;
    logic [31:0] p_addr, p_wd;
    logic        p_we;
    logic        last_oe;

    function automatic int idx(logic [31:0] a);
        return int'(a[7:2]);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model with its own port stability monitor (R11)
    always @(negedge clk) begin
        if (rst) begin
            mem_ack   = 1'b0;
            mem_rdata = '0;
            lat_cnt   = 0;
            hold_open = 0;
        end else begin
            if (hold_open && !(mem_req === 1'b1 && mem_addr === p_addr &&
                               mem_we === p_we && mem_wdata === p_wd))
                hold_viol++;
            if (mem_req) req_cycles++;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat_cnt >= mem_lat) begin
                    mem_ack = 1'b1;
                    lat_cnt = 0;
                    if (mem_we) mem[idx(mem_addr)] = mem_wdata;
                    else        mem_rdata = mem[idx(mem_addr)];
                end else begin
                    lat_cnt++;
                end
            end
            hold_open = mem_req && !mem_ack;
            p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst && not_ready === 1'b1) busy_cycles++;
    end

    task automatic wait_ready();
        while (not_ready !== 1'b0) @(negedge clk);
    endtask

    task automatic wait_mem_idle();
        while (mem_req !== 1'b0) @(negedge clk);
    endtask

    task automatic half_acc(input logic [1:0] rs, input logic rnw, input logic hw,
                            input logic [15:0] wd, output logic [15:0] rd);
        bit use_b;
        use_b = 1'($urandom_range(0, 1));
        @(negedge clk);
        reg_sel = rs; rd_wr_n = rnw; half_sel = hw; hd_in = wd; cs_n = 1'b0;
        @(negedge clk);
        wait_ready();
        if (use_b) dstb_b_n = 1'b0; else dstb_a_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wait_ready();
        rd = hd_out;
        last_oe = hd_oe;
        dstb_a_n = 1'b1; dstb_b_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic wr_word(input logic [1:0] rs, input logic [31:0] w);
        logic [15:0] d;
        half_acc(rs, 1'b0, 1'b0, w[15:0], d);
        half_acc(rs, 1'b0, 1'b1, w[31:16], d);
        case (rs)
            S_CTRL: exp_ctrl = w;
            S_ADDR: exp_addr = w;
            default: begin
                exp_mem[idx(exp_addr)] = w;
                if (rs == S_INC) exp_addr = exp_addr + 32'd4;
            end
        endcase
    endtask

    task automatic rd_word(input logic [1:0] rs, output logic [31:0] w);
        logic [15:0] lo, hi;
        half_acc(rs, 1'b1, 1'b0, 16'h0, lo);
        half_acc(rs, 1'b1, 1'b1, 16'h0, hi);
        w = {hi, lo};
    endtask

    function automatic logic [31:0] exp_read(logic [1:0] rs);
        case (rs)
            S_CTRL:  return exp_ctrl;
            S_ADDR:  return exp_addr;
            default: return exp_mem[idx(exp_addr)];
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, e;
        logic [15:0] h;
        int r0, b0;
        void'($urandom(32'd20240611));
        rst = 1'b1; cs_n = 1'b1; dstb_a_n = 1'b1; dstb_b_n = 1'b1;
        reg_sel = 2'b00; rd_wr_n = 1'b0; half_sel = 1'b0; hd_in = '0;
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 32'h5A5A0000 + 32'(i) * 32'h00010203;
            exp_mem[i] = mem[i];
        end
        exp_ctrl = '0; exp_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check("R12", {31'd0, not_ready}, 32'd0, "not_ready after reset");
        check("R12", {31'd0, mem_req}, 32'd0, "mem_req after reset");
        check("R12", {31'd0, hd_oe}, 32'd0, "hd_oe after reset");
        rd_word(S_CTRL, w); check("R12", w, 32'd0, "control after reset");
        rd_word(S_ADDR, w); check("R12", w, 32'd0, "address after reset");

        // R3 / R8: control and address registers, no memory traffic, ready untouched
        r0 = req_cycles; b0 = busy_cycles;
        wr_word(S_CTRL, 32'h1234ABCD);
        check("R3", {31'd0, last_oe}, 32'd0, "hd_oe on write strobe");
        rd_word(S_CTRL, w); check("R3", w, exp_ctrl, "control readback");
        check("R3", {31'd0, last_oe}, 32'd1, "hd_oe on read strobe");
        wr_word(S_ADDR, 32'h00000040);
        rd_word(S_ADDR, w); check("R3", w, 32'h00000040, "address readback");
        check("R8", 32'(req_cycles - r0), 32'd0, "memory requests on register access");
        check("R8", 32'(busy_cycles - b0), 32'd0, "not_ready cycles on register access");

        // R6: non-increment word write
        mem_lat = 4;
        b0 = busy_cycles;
        wr_word(S_DATA, 32'hCAFE1357);
        wait_mem_idle();
        check("R6", mem[idx(32'h40)], 32'hCAFE1357, "assembled memory word");
        check("R6", {31'd0, (busy_cycles > b0)}, 32'd1, "not_ready after high-half write");
        rd_word(S_ADDR, w); check("R6", w, 32'h00000040, "address after plain write");

        // R5 / R10: non-increment reads fetch every time
        mem_lat = 3;
        r0 = req_cycles; b0 = busy_cycles;
        rd_word(S_DATA, w); check("R5", w, exp_read(S_DATA), "fetched word");
        check("R5", {31'd0, (busy_cycles > b0)}, 32'd1, "not_ready during fetch");
        rd_word(S_DATA, w); check("R10", w, exp_read(S_DATA), "second fetched word");
        check("R10", {31'd0, (req_cycles - r0 >= 8)}, 32'd1, "two fetch requests issued");
        rd_word(S_ADDR, w); check("R10", w, 32'h00000040, "address after plain reads");

        // R7: autoincrement writes
        mem_lat = 1;
        wr_word(S_ADDR, 32'h00000080);
        wr_word(S_INC, 32'h11112222);
        wr_word(S_INC, 32'h33334444);
        wr_word(S_INC, 32'h55556666);
        wait_mem_idle();
        check("R7", mem[idx(32'h84)], 32'h33334444, "second autoincrement word");
        rd_word(S_ADDR, w); check("R7", w, 32'h0000008C, "address after three writes");

        // R7: autoincrement read, prefetch, then a control access, then a prefetched low half
        wr_word(S_ADDR, 32'h00000080);
        rd_word(S_INC, w); check("R7", w, 32'h11112222, "first autoincrement read");
        exp_addr = exp_addr + 32'd4;
        wr_word(S_CTRL, 32'h0F0F0F0F);
        r0 = req_cycles;
        half_acc(S_INC, 1'b1, 1'b0, 16'h0, h);
        check("R7", 32'(req_cycles - r0), 32'd0, "requests for prefetched low half");
        check("R7", {16'd0, h}, {16'd0, 16'h4444}, "prefetched low half");
        half_acc(S_INC, 1'b1, 1'b1, 16'h0, h);
        check("R7", {16'd0, h}, {16'd0, 16'h3333}, "prefetched high half");
        exp_addr = exp_addr + 32'd4;
        wait_mem_idle();
        rd_word(S_ADDR, w); check("R7", w, 32'h00000088, "address after two reads");

        // R1: both strobes low, or chip select high, start nothing
        @(negedge clk);
        reg_sel = S_CTRL; rd_wr_n = 1'b0; half_sel = 1'b0; hd_in = 16'hFFFF; cs_n = 1'b0;
        @(negedge clk); dstb_a_n = 1'b0; dstb_b_n = 1'b0;
        repeat (3) @(negedge clk);
        dstb_a_n = 1'b1; dstb_b_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk); dstb_a_n = 1'b0;
        repeat (3) @(negedge clk);
        dstb_a_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_word(S_CTRL, w); check("R1", w, exp_ctrl, "control after non-strobes");

        // R2: selects changed after the fall are ignored
        @(negedge clk);
        reg_sel = S_CTRL; rd_wr_n = 1'b0; half_sel = 1'b0; hd_in = 16'h5A3C; cs_n = 1'b0;
        @(negedge clk); dstb_a_n = 1'b0;
        @(negedge clk); reg_sel = S_ADDR; half_sel = 1'b1; rd_wr_n = 1'b1;
        @(negedge clk);
        check("R2", {31'd0, hd_oe}, 32'd0, "hd_oe follows captured direction");
        @(negedge clk); wait_ready();
        dstb_a_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        exp_ctrl[15:0] = 16'h5A3C;
        rd_word(S_CTRL, w); check("R2", w, exp_ctrl, "control after select change");
        rd_word(S_ADDR, w); check("R2", w, exp_addr, "address untouched by select change");

        // R4 / R9: slow memory, chip select high then low during a write
        mem_lat = 8;
        wr_word(S_DATA, 32'hBEEF0001);
        @(negedge clk);
        check("R4", {30'd0, mem_req, not_ready}, 32'd2, "req pending, ready with cs high");
        cs_n = 1'b0;
        @(negedge clk);
        check("R9", {31'd0, not_ready}, 32'd1, "not_ready at cs fall while busy");
        cs_n = 1'b1;
        wait_mem_idle();
        check("R6", mem[idx(exp_addr)], 32'hBEEF0001, "slow write landed");

        // Random mix of accesses against the bench model
        for (int n = 0; n < 150; n++) begin
            int op;
            op = int'($urandom_range(0, 5));
            mem_lat = int'($urandom_range(0, 3));
            case (op)
                0: wr_word(S_INC, $urandom());
                1: wr_word(S_DATA, $urandom());
                2, 3: begin
                    e = exp_read(op == 2 ? S_INC : S_DATA);
                    rd_word(op == 2 ? S_INC : S_DATA, w);
                    check(op == 2 ? "R7" : "R10", w, e, "random data read");
                    if (op == 2) exp_addr = exp_addr + 32'd4;
                end
                4: wr_word(S_ADDR, {24'd0, 6'($urandom_range(0, 63)), 2'b00});
                default: begin
                    wr_word(S_CTRL, $urandom());
                    rd_word(S_CTRL, w); check("R3", w, exp_ctrl, "random control read");
                end
            endcase
        end
        wait_mem_idle();
        rd_word(S_ADDR, w); check("R7", w, exp_addr, "address after random mix");
        check("R11", 32'(hold_viol), 32'd0, "memory port changes while pending");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule